// File: doc/BRIEF.md
# Two-Register I2C Control Slave for Dual Power Channels

This block is an I2C target that holds the configuration of two supply channels in two 8-bit registers. A host writes one data byte per register update. The top bit of that byte chooses the register that receives the lower bits. A read transfer returns the register images in turn. Each image carries the bits as last written, plus live diagnostic flags: over-temperature and one overload flag per channel. The protection logic drives these flags directly into the block.

SCL and SDA are sampled by the system clock, which must run at least 20 times faster than SCL. The target answers on the 7-bit address 000100A, where A is an address strap input. The block is held reset while power-ok is low. A rising over-temperature flag wipes every writable bit. The decoded register fields leave the block as individual control outputs.

Top module: `dual_chan_i2c_regs`

## Requirements
- R1: The block pulls SDA low during the ninth SCL clock of an address byte if and only if the byte's upper seven bits equal 000100 followed by the `addr_strap` value. The byte's LSB is the read (1) / write (0) flag.
- R2: After an address that does not match, the block neither acknowledges nor stores any byte until the next START or STOP.
- R3: Each written data byte is acknowledged on its ninth clock. If its bit 7 is 0, its bits 6..1 are loaded into channel-1 register bits 6..1: `static_clamp`, `ch1_hi_cur`, `ch1_tone`, `ch1_comp`, `ch1_v18`, `ch1_en`. If its bit 7 is 1, its bits 6..2 are loaded into `ch2_hi_cur`, `ch2_tone`, `ch2_comp`, `ch2_v18`, `ch2_en`. Bits in read-only positions are discarded, and the other register is left unchanged.
- R4: A read transfer sends, MSB first, the channel-1 image, then the channel-2 image, and then alternates between them on each master ACK. Every START restarts the sequence at the channel-1 image.
- R5: Bit 7 of a read image is the register index (0 or 1). The channel-1 image is {0, its bits 6..1 as written, `ovl1_flag`}. The channel-2 image is {1, its bits 6..2 as written, `ot_flag`, `ovl2_flag`}. The flags are sampled live when each byte is loaded.
- R6: After a master NACK the block releases SDA and drives nothing until the next START.
- R7: While `pwr_ok` is low, both registers read as zero, all field outputs are 0, and SDA is never pulled.
- R8: A rising edge on `ot_flag` clears all writable bits of both registers. When a write commit lands in the same clock as that edge, the clear wins.
- R9: After reset all field outputs are 0 and `sda_pull` is 0.
- R10: `sda_pull` changes only while the sampled SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| addr_strap | input | 1 | Selects address LSB |
| pwr_ok | input | 1 | Supply good; low holds the block in reset |
| ot_flag | input | 1 | Over-temperature diagnostic |
| ovl1_flag | input | 1 | Channel 1 overload diagnostic |
| ovl2_flag | input | 1 | Channel 2 overload diagnostic |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| static_clamp | output | 1 | 1 = static current clamp, 0 = dynamic limiting |
| ch1_hi_cur | output | 1 | Channel 1 high current threshold |
| ch1_tone | output | 1 | Channel 1 continuous tone |
| ch1_comp | output | 1 | Channel 1 cable drop compensation |
| ch1_v18 | output | 1 | Channel 1 high voltage select |
| ch1_en | output | 1 | Channel 1 enable |
| ch2_hi_cur | output | 1 | Channel 2 high current threshold |
| ch2_tone | output | 1 | Channel 2 continuous tone |
| ch2_comp | output | 1 | Channel 2 cable drop compensation |
| ch2_v18 | output | 1 | Channel 2 high voltage select |
| ch2_en | output | 1 | Channel 2 enable |

## Verification
A data-byte write commit and an over-temperature clear can fall in the same system clock. The bench provokes this by raising `ot_flag` at a swept offset of one to four cycles after it drives the final SCL rise of a data byte. The bench's expectation follows from the synchronizer depth: a rise seen before the commit leaves the newly written value in place. A rise on the commit clock or later leaves both registers zero, and this is judged at the field outputs.

// File: rtl/dcr_pkg.sv
// Shared types and constants for the two-register I2C control slave.
// Assumes a fixed 8-bit I2C byte; everything else is parameterised at the top.
package dcr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam int CH1_W  = 6;  // writable bits 6..1 of register 0
    localparam int CH2_W  = 5;  // writable bits 6..2 of register 1

    typedef enum logic [2:0] {
        S_IDLE,   // bus free or not addressed
        S_ADDR,   // shifting address byte
        S_AACK,   // address acknowledge slot
        S_WR,     // shifting data byte from master
        S_WACK,   // data acknowledge slot
        S_RD,     // driving data byte to master
        S_RACK,   // master acknowledge slot
        S_SKIP    // ignore bus until START/STOP
    } eng_state_t;
endpackage

// File: rtl/bus_sampler.sv
// Synchronises SCL/SDA into the system clock and flags SCL edges, START and STOP.
// Assumes the system clock runs at least 20x the SCL rate; idle line level is 1.
module bus_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                // first stage captures the raw lines
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_pipe[0] <= 1'b1;
                        sda_pipe[0] <= 1'b1;
                    end else begin
                        scl_pipe[0] <= scl_i;
                        sda_pipe[0] <= sda_i;
                    end
                end
            end else begin : g_next
                // later stages retime the previous stage
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_pipe[g] <= 1'b1;
                        sda_pipe[g] <= 1'b1;
                    end else begin
                        scl_pipe[g] <= scl_pipe[g-1];
                        sda_pipe[g] <= sda_pipe[g-1];
                    end
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // one-cycle history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_target_engine.sv
// Byte-level I2C target: address match, write strobe, read serialiser, ACK slots.
// Assumes edge strobes from bus_sampler; run_n low holds it idle and silent.
module i2c_target_engine
    import dcr_pkg::*;
#(
    parameter logic [5:0] ADDR_HI = 6'b000100
) (
    input  logic              clk,
    input  logic              run_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              addr_strap,
    input  logic [BYTE_W-1:0] img0,
    input  logic [BYTE_W-1:0] img1,
    output logic              sda_pull,
    output logic              wr_stb,
    output logic [BYTE_W-2:0] wr_hi
);
    eng_state_t        state;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-2:0] shreg;
    logic              rw;
    logic              ptr;
    logic [BYTE_W-1:0] next_img;
    logic              last_bit;

    // image selected by the read pointer
    assign next_img = ptr ? img1 : img0;
    assign last_bit = (bitcnt == CNT_W'(BYTE_W - 1));

    // write commit on the eighth SCL rise of a data byte
    assign wr_stb = (state == S_WR) && scl_rise && last_bit;
    assign wr_hi  = shreg;

    // protocol sequencer
    always_ff @(posedge clk) begin
        if (!run_n) begin
            state    <= S_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            rw       <= 1'b0;
            ptr      <= 1'b0;
            sda_pull <= 1'b0;
        end else if (start_det) begin
            state    <= S_ADDR;
            bitcnt   <= '0;
            ptr      <= 1'b0;
            sda_pull <= 1'b0;
        end else if (stop_det) begin
            state    <= S_IDLE;
            sda_pull <= 1'b0;
        end else begin
            unique case (state)
                S_ADDR: if (scl_rise) begin
                    shreg  <= {shreg[BYTE_W-3:0], sda_s};
                    bitcnt <= bitcnt + 1'b1;
                    if (last_bit) begin
                        if (shreg == {ADDR_HI, addr_strap}) begin
                            rw    <= sda_s;
                            state <= S_AACK;
                        end else begin
                            state <= S_SKIP;
                        end
                    end
                end
                S_AACK: if (scl_fall) begin
                    if (!sda_pull) begin
                        sda_pull <= 1'b1;
                    end else if (rw) begin
                        shreg    <= next_img[BYTE_W-2:0];
                        sda_pull <= ~next_img[BYTE_W-1];
                        ptr      <= ~ptr;
                        bitcnt   <= '0;
                        state    <= S_RD;
                    end else begin
                        sda_pull <= 1'b0;
                        bitcnt   <= '0;
                        state    <= S_WR;
                    end
                end
                S_WR: if (scl_rise) begin
                    shreg  <= {shreg[BYTE_W-3:0], sda_s};
                    bitcnt <= bitcnt + 1'b1;
                    if (last_bit) state <= S_WACK;
                end
                S_WACK: if (scl_fall) begin
                    if (!sda_pull) begin
                        sda_pull <= 1'b1;
                    end else begin
                        sda_pull <= 1'b0;
                        state    <= S_WR;
                    end
                end
                S_RD: if (scl_fall) begin
                    if (last_bit) begin
                        sda_pull <= 1'b0;
                        state    <= S_RACK;
                    end else begin
                        sda_pull <= ~shreg[BYTE_W-2];
                        shreg    <= {shreg[BYTE_W-3:0], 1'b0};
                        bitcnt   <= bitcnt + 1'b1;
                    end
                end
                S_RACK: begin
                    if (scl_rise && sda_s) begin
                        state <= S_SKIP;
                    end else if (scl_fall) begin
                        shreg    <= next_img[BYTE_W-2:0];
                        sda_pull <= ~next_img[BYTE_W-1];
                        ptr      <= ~ptr;
                        bitcnt   <= '0;
                        state    <= S_RD;
                    end
                end
                default: ;
            endcase
        end
    end

    logic run_q;
    // remembers whether the previous cycle was out of reset
    always_ff @(posedge clk) run_q <= run_n;

    assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (!run_n)
        (run_q && !$stable(sda_pull)) |-> !scl_s);
    assert_pull_in_slot_R1: assert property (@(posedge clk) disable iff (!run_n)
        sda_pull |-> (state == S_AACK || state == S_WACK || state == S_RD));
    assert_skip_silent_R2: assert property (@(posedge clk) disable iff (!run_n)
        (state == S_SKIP) |-> !sda_pull);
endmodule

// File: rtl/chan_reg_bank.sv
// Holds the writable bits of both channel registers and builds the read images.
// Assumes ot_flag is synchronous to clk; its rising edge clears and beats writes.
module chan_reg_bank
    import dcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_n,
    input  logic              ot_flag,
    input  logic              ovl1_flag,
    input  logic              ovl2_flag,
    input  logic              wr_stb,
    input  logic [BYTE_W-2:0] wr_hi,
    output logic [CH1_W-1:0]  ch1_bits,
    output logic [CH2_W-1:0]  ch2_bits,
    output logic [BYTE_W-1:0] img0,
    output logic [BYTE_W-1:0] img1
);
    logic ot_q;
    logic ot_rise;

    // history of the over-temperature flag
    always_ff @(posedge clk) begin
        if (!run_n) ot_q <= 1'b0;
        else        ot_q <= ot_flag;
    end
    assign ot_rise = ot_flag & ~ot_q;

    // register storage: power-down, thermal clear, then host write
    always_ff @(posedge clk) begin
        if (!run_n || ot_rise) begin
            ch1_bits <= '0;
            ch2_bits <= '0;
        end else if (wr_stb) begin
            if (wr_hi[BYTE_W-2]) ch2_bits <= wr_hi[CH2_W:1];
            else                 ch1_bits <= wr_hi[CH1_W-1:0];
        end
    end

    assign img0 = {1'b0, ch1_bits, ovl1_flag};
    assign img1 = {1'b1, ch2_bits, ot_flag, ovl2_flag};

    assert_zero_unpowered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_n |=> (ch1_bits == '0 && ch2_bits == '0));
    assert_ot_clear_R8: assert property (@(posedge clk) disable iff (!run_n)
        $rose(ot_flag) |=> (ch1_bits == '0 && ch2_bits == '0));
    assert_write_ch1_R3: assert property (@(posedge clk) disable iff (!run_n)
        (wr_stb && !wr_hi[BYTE_W-2] && !$rose(ot_flag)) |=>
        (ch1_bits == $past(wr_hi[CH1_W-1:0]) && $stable(ch2_bits)));
endmodule

// File: rtl/dual_chan_i2c_regs.sv
// Top: I2C target with two channel registers decoded to control outputs.
// Assumes clk >= 20x SCL; pwr_ok low acts as a synchronous reset of the target.
module dual_chan_i2c_regs #(
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] ADDR_HI     = 6'b000100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic addr_strap,
    input  logic pwr_ok,
    input  logic ot_flag,
    input  logic ovl1_flag,
    input  logic ovl2_flag,
    output logic sda_pull,
    output logic static_clamp,
    output logic ch1_hi_cur,
    output logic ch1_tone,
    output logic ch1_comp,
    output logic ch1_v18,
    output logic ch1_en,
    output logic ch2_hi_cur,
    output logic ch2_tone,
    output logic ch2_comp,
    output logic ch2_v18,
    output logic ch2_en
);
    import dcr_pkg::*;

    logic              run_n;
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_stb;
    logic [BYTE_W-2:0] wr_hi;
    logic [BYTE_W-1:0] img0, img1;
    logic [CH1_W-1:0]  ch1_bits;
    logic [CH2_W-1:0]  ch2_bits;

    assign run_n = rst_n & pwr_ok;

    bus_sampler #(.STAGES(SYNC_STAGES)) u_samp (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_target_engine #(.ADDR_HI(ADDR_HI)) u_eng (
        .clk(clk), .run_n(run_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .addr_strap(addr_strap), .img0(img0), .img1(img1),
        .sda_pull(sda_pull), .wr_stb(wr_stb), .wr_hi(wr_hi)
    );

    chan_reg_bank u_bank (
        .clk(clk), .rst_n(rst_n), .run_n(run_n), .ot_flag(ot_flag),
        .ovl1_flag(ovl1_flag), .ovl2_flag(ovl2_flag), .wr_stb(wr_stb),
        .wr_hi(wr_hi), .ch1_bits(ch1_bits), .ch2_bits(ch2_bits),
        .img0(img0), .img1(img1)
    );

    assign {static_clamp, ch1_hi_cur, ch1_tone, ch1_comp, ch1_v18, ch1_en} = ch1_bits;
    assign {ch2_hi_cur, ch2_tone, ch2_comp, ch2_v18, ch2_en}               = ch2_bits;

    assert_silent_unpowered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> !sda_pull);
endmodule

// File: tb/sim_dual_chan_i2c_regs.sv
`timescale 1ns/1ps
module sim_dual_chan_i2c_regs;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic strap = 1'b0, pwr_ok = 1'b1, ot = 1'b0, ovl1 = 1'b0, ovl2 = 1'b0;
    logic sda_pull;
    logic clamp, h1, t1, c1, v1, e1, h2, t2, c2, v2, e2;
    wire  sda_bus = sda_m & ~sda_pull;
    wire [5:0] got1 = {clamp, h1, t1, c1, v1, e1};
    wire [4:0] got2 = {h2, t2, c2, v2, e2};

    int n_cmp = 0, n_bad = 0, viol = 0;
    localparam int Q = 5;
    event ev_mark;

    always #5 clk = ~clk;

    dual_chan_i2c_regs u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .addr_strap(strap),
        .pwr_ok(pwr_ok), .ot_flag(ot), .ovl1_flag(ovl1), .ovl2_flag(ovl2),
        .sda_pull(sda_pull), .static_clamp(clamp), .ch1_hi_cur(h1), .ch1_tone(t1),
        .ch1_comp(c1), .ch1_v18(v1), .ch1_en(e1), .ch2_hi_cur(h2), .ch2_tone(t2),
        .ch2_comp(c2), .ch2_v18(v2), .ch2_en(e2)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; scl_m = 1'b1; wq(2*Q);
        sda_m = 1'b0; wq(2*Q);
        scl_m = 1'b0;
    endtask

    task automatic i2c_stop();
        wq(Q); sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    // one bit slot: drive b (1 = release), return the bus level mid-high
    task automatic slot(input logic b, input logic mark, output logic seen);
        wq(Q); sda_m = b; wq(Q);
        scl_m = 1'b1;
        if (mark) ->ev_mark;
        wq(Q); seen = sda_bus; wq(Q);
        scl_m = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] b, input logic mark, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) slot(b[i], mark && (i == 0), s);
        slot(1'b1, 1'b0, s);
        ack = ~s;
    endtask

    task automatic rd_byte(input logic ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            slot(1'b1, 1'b0, s);
            b[i] = s;
        end
        slot(~ack, 1'b0, s);
    endtask

    // complete one-byte register write; returns both ACKs
    task automatic reg_write(input logic [7:0] d, output logic a0, output logic a1);
        i2c_start();
        wr_byte({6'b000100, strap, 1'b0}, 1'b0, a0);
        wr_byte(d, 1'b0, a1);
        i2c_stop();
    endtask

    // R10 monitor: slave drive must not move while SCL is held high
    logic scl_prev = 1'b1, pull_prev = 1'b0;
    always @(posedge clk) begin
        #1;
        if (rst_n && pwr_ok && scl_m && scl_prev && (sda_pull !== pull_prev)) viol++;
        scl_prev  = scl_m;
        pull_prev = sda_pull;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic a0, a1;
        logic [7:0] rb;
        logic [5:0] exp1;
        logic [4:0] exp2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        wq(4);
        // R9 reset state
        chk("R9 fields", {got1, got2}, 0);
        chk("R9 sda_pull", sda_pull, 0);

        // R1 address sweep, both strap values
        for (int s = 0; s < 2; s++) begin
            strap = s[0];
            for (int a = 0; a < 128; a++) begin
                i2c_start();
                wr_byte({a[6:0], 1'b0}, 1'b0, a0);
                i2c_stop();
                chk($sformatf("R1 addr %0h strap %0d", a, s), a0,
                    (a[6:0] == {6'b000100, s[0]}) ? 1 : 0);
            end
        end
        strap = 1'b0;

        // R3 channel-1 exhaustive, bit0 junk must be dropped
        exp2 = '0;
        for (int v = 0; v < 64; v++) begin
            reg_write({1'b0, v[5:0], ~v[0]}, a0, a1);
            chk("R3 ch1 acks", {a0, a1}, 2'b11);
            chk("R3 ch1 fields", {got1, got2}, {v[5:0], exp2});
        end
        exp1 = 6'd63;
        // R3 channel-2 exhaustive, read-only positions junk
        for (int v = 0; v < 32; v++) begin
            reg_write({1'b1, v[4:0], 2'b11}, a0, a1);
            chk("R3 ch2 acks", {a0, a1}, 2'b11);
            chk("R3 ch2 fields", {got1, got2}, {exp1, v[4:0]});
        end
        exp2 = 5'd31;

        // R2 wrong address: no ACK, no store
        i2c_start();
        wr_byte({7'h10, 1'b0}, 1'b0, a0);
        wr_byte(8'h00, 1'b0, a1);
        i2c_stop();
        chk("R2 no acks", {a0, a1}, 2'b00);
        chk("R2 regs kept", {got1, got2}, {exp1, exp2});

        // R4/R5 read sequence with live flags
        ot = 1'b1; wq(3);
        reg_write(8'h5A, a0, a1);      // ch1 = 101101
        reg_write(8'hD9, a0, a1);      // ch2 = 10110
        ovl1 = 1'b1; ovl2 = 1'b0;
        i2c_start();
        wr_byte({6'b000100, strap, 1'b1}, 1'b0, a0);
        chk("R1 read addr ack", a0, 1);
        rd_byte(1'b1, rb); chk("R4 R5 first image ch1", rb, {1'b0, 6'b101101, 1'b1});
        rd_byte(1'b1, rb); chk("R4 R5 second image ch2", rb, {1'b1, 5'b10110, 1'b1, 1'b0});
        rd_byte(1'b0, rb); chk("R4 third image ch1", rb, {1'b0, 6'b101101, 1'b1});
        rd_byte(1'b0, rb); chk("R6 released after NACK", rb, 8'hFF);
        i2c_stop();
        ot = 1'b0; ovl1 = 1'b0; ovl2 = 1'b1;
        i2c_start();
        wr_byte({6'b000100, strap, 1'b1}, 1'b0, a0);
        rd_byte(1'b1, rb); chk("R4 restart at ch1", rb, {1'b0, 6'b101101, 1'b0});
        rd_byte(1'b0, rb); chk("R5 live flags ch2", rb, {1'b1, 5'b10110, 1'b0, 1'b1});
        i2c_stop();

        // R8 thermal clear versus same-cycle write commit
        for (int n = 1; n <= 4; n++) begin
            reg_write(8'h00, a0, a1);
            reg_write(8'hFC, a0, a1);
            fork
                begin
                    i2c_start();
                    wr_byte({6'b000100, strap, 1'b0}, 1'b0, a0);
                    wr_byte(8'h7E, 1'b1, a1);
                    i2c_stop();
                end
                begin
                    @ev_mark;
                    repeat (n) @(negedge clk);
                    ot = 1'b1;
                end
            join
            chk($sformatf("R8 offset %0d ch1", n), got1, (n <= 1) ? 6'd63 : 6'd0);
            chk($sformatf("R8 offset %0d ch2", n), got2, 0);
            ot = 1'b0; wq(3);
        end

        // R7 power-ok low
        reg_write(8'h7E, a0, a1);
        pwr_ok = 1'b0; wq(3);
        chk("R7 regs zero", {got1, got2}, 0);
        reg_write(8'h2A, a0, a1);
        chk("R7 no ack", {a0, a1}, 2'b00);
        chk("R7 still zero", {got1, got2}, 0);
        pwr_ok = 1'b1; wq(3);
        reg_write(8'h2A, a0, a1);
        chk("R7 recover acks", {a0, a1}, 2'b11);
        chk("R7 recover value", got1, 6'b010101);

        chk("R10 pull stable while SCL high", viol, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule